// File: doc/BRIEF.md
# Retirement Liveness and Uniqueness Window Checker

This block watches a single-channel instruction retirement trace and judges one reference instruction per observation window. While the reset input is held, the checker settles and ignores the trace. After release, a trigger pulse during a valid retirement captures that instruction's order index K and its halt flag. From the next cycle until the window is closed by a check, the block watches every retirement. A retirement that repeats index K breaks uniqueness. If the check arrives and no retirement with index K+1 has appeared, liveness is broken, unless instruction K reported halt.

The window can be closed by an external check input, or by a built-in cycle counter that closes it a fixed number of cycles after reset release. Each failure sets its own sticky error output, and only reset clears it. A trigger in a cycle with no valid retirement captures nothing, so both checks then pass without condition.

Top module: `retire_window_chk`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `errLive` and `errDup` are 0, and no reference is held.
- R2: A cycle with `trigger` and `retValid` both high, before the window has closed and with no reference held, captures `retOrder` as K and `retHalt` as the halt flag. Later triggers are ignored until reset.
- R3: `trigger` in a cycle with `retValid` low captures nothing. A check with no reference held raises neither error.
- R4: From the cycle after capture up to and including the check cycle, a valid retirement with order equal to K sets `errDup` at the next clock edge.
- R5: In the check cycle, if no valid retirement with order K+1 has been seen since the cycle after capture (the check cycle counts), `errLive` is set at the next clock edge.
- R6: If the captured halt flag is 1, `errLive` is never set for that window.
- R7: K+1 is computed modulo 2^ORDER_W, so the successor of the all-ones index is 0.
- R8: Both error outputs stay high once set, until `rst`.
- R9: After the first check following reset, the window is closed. Later retirements, triggers and checks change neither error output.
- R10: With AUTO_CHECK=1, a check occurs by itself in the cycle numbered WINDOW-1, counting the first cycle after reset release as cycle 0. `checkIn` is honoured as well, and whichever comes first closes the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset; holds the checker in its settling phase |
| retValid | input | 1 | A retirement is reported this cycle |
| retOrder | input | ORDER_W | Order index of the retiring instruction |
| retHalt | input | 1 | Retiring instruction is the last one (halt) |
| trigger | input | 1 | Capture the current retirement as reference |
| checkIn | input | 1 | External end-of-window check |
| errLive | output | 1 | Sticky: successor of the reference never retired in the window |
| errDup | output | 1 | Sticky: reference index retired a second time |

## Verification
On every cycle, the assertions enforce that both error flags are sticky, and that `errLive` rises only right after a check. They also enforce that `errDup` rises only right after a valid retirement, that at most one reference is captured per reset, and that nothing is captured or judged once the window has closed. The match of specific index values can only be shown by the bench's scenarios. These include the duplicate and successor comparisons, wrap of the all-ones index, the halt exemption, a vacuous trigger, a successor in the check cycle itself, and the exact cycle in which the built-in counter closes the window.

// File: rtl/retire_chk_pkg.sv
package retire_chk_pkg;

  typedef struct packed {
    logic latchRef;   // capture current retirement as reference
    logic observe;    // reference held, window open: compare retirements
    logic evalCheck;  // judge liveness this cycle
  } chkStrobe_t;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_ARMED  = 2'd1,
    PH_CLOSED = 2'd2
  } chkPhase_e;

endpackage

// File: rtl/retire_chk_ctrl.sv
module retire_chk_ctrl
  import retire_chk_pkg::*;
#(
  parameter int WINDOW     = 16,
  parameter bit AUTO_CHECK = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       retValid,
  input  logic       trigger,
  input  logic       checkIn,
  output chkStrobe_t strobe,
  output logic       checkEff
);

  localparam int CNT_W = $clog2(WINDOW + 1);

  chkPhase_e phase, phaseNext;
  logic autoHit;

  generate
    if (AUTO_CHECK) begin : g_auto
      logic [CNT_W-1:0] winCnt;
      always_ff @(posedge clk) begin
        if (rst) begin
          winCnt <= '0;
        end else if (winCnt != CNT_W'(WINDOW)) begin
          winCnt <= winCnt + 1'b1;
        end
      end
      assign autoHit = (winCnt == CNT_W'(WINDOW - 1));
    end else begin : g_manual
      assign autoHit = 1'b0;
    end
  endgenerate

  assign checkEff = checkIn | autoHit;

  always_comb begin
    strobe    = '0;
    phaseNext = phase;
    case (phase)
      PH_IDLE: begin
        if (checkEff) begin
          phaseNext = PH_CLOSED;
        end else if (trigger && retValid) begin
          strobe.latchRef = 1'b1;
          phaseNext       = PH_ARMED;
        end
      end
      PH_ARMED: begin
        strobe.observe = 1'b1;
        if (checkEff) begin
          strobe.evalCheck = 1'b1;
          phaseNext        = PH_CLOSED;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) phase <= PH_IDLE;
    else     phase <= phaseNext;
  end

endmodule

// File: rtl/retire_chk_dp.sv
module retire_chk_dp
  import retire_chk_pkg::*;
#(
  parameter int ORDER_W = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  chkStrobe_t         strobe,
  input  logic               retValid,
  input  logic [ORDER_W-1:0] retOrder,
  input  logic               retHalt,
  output logic               errLive,
  output logic               errDup
);

  localparam logic [ORDER_W-1:0] ONE = {{(ORDER_W-1){1'b0}}, 1'b1};

  logic [ORDER_W-1:0] refOrder;
  logic [ORDER_W-1:0] nextOrder;
  logic refHalt;
  logic seenNext;
  logic hitRef;
  logic hitNext;

  assign nextOrder = refOrder + ONE;   // wraps modulo 2^ORDER_W
  assign hitRef    = retValid && (retOrder == refOrder);
  assign hitNext   = retValid && (retOrder == nextOrder);

  always_ff @(posedge clk) begin
    if (rst) begin
      refOrder <= '0;
      refHalt  <= 1'b0;
      seenNext <= 1'b0;
      errLive  <= 1'b0;
      errDup   <= 1'b0;
    end else begin
      if (strobe.latchRef) begin
        refOrder <= retOrder;
        refHalt  <= retHalt;
        seenNext <= 1'b0;
      end
      if (strobe.observe && hitRef)  errDup   <= 1'b1;
      if (strobe.observe && hitNext) seenNext <= 1'b1;
      if (strobe.evalCheck && !refHalt && !seenNext && !hitNext) errLive <= 1'b1;
    end
  end

endmodule

// File: rtl/retire_window_chk.sv
module retire_window_chk
  import retire_chk_pkg::*;
#(
  parameter int ORDER_W    = 64,
  parameter int WINDOW     = 16,
  parameter bit AUTO_CHECK = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               retValid,
  input  logic [ORDER_W-1:0] retOrder,
  input  logic               retHalt,
  input  logic               trigger,
  input  logic               checkIn,
  output logic               errLive,
  output logic               errDup
);

  chkStrobe_t strobe;
  logic checkEff;

  retire_chk_ctrl #(
    .WINDOW    (WINDOW),
    .AUTO_CHECK(AUTO_CHECK)
  ) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .retValid(retValid),
    .trigger (trigger),
    .checkIn (checkIn),
    .strobe  (strobe),
    .checkEff(checkEff)
  );

  retire_chk_dp #(
    .ORDER_W(ORDER_W)
  ) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .retValid(retValid),
    .retOrder(retOrder),
    .retHalt (retHalt),
    .errLive (errLive),
    .errDup  (errDup)
  );

endmodule

// File: rtl/retire_window_chk_sva.sv
module retire_window_chk_sva (
  input logic clk,
  input logic rst,
  input logic retValid,
  input logic checkEff,
  input logic latchRef,
  input logic evalCheck,
  input logic errLive,
  input logic errDup
);

  logic sawLatch;
  logic sawCheck;

  always_ff @(posedge clk) begin
    if (rst) begin
      sawLatch <= 1'b0;
      sawCheck <= 1'b0;
    end else begin
      if (latchRef) sawLatch <= 1'b1;
      if (checkEff) sawCheck <= 1'b1;
    end
  end

  p_live_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    errLive |=> errLive);

  p_dup_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    errDup |=> errDup);

  p_live_after_check_r5: assert property (@(posedge clk) disable iff (rst)
    !errLive ##1 errLive |-> $past(checkEff));

  p_dup_after_retire_r4: assert property (@(posedge clk) disable iff (rst)
    !errDup ##1 errDup |-> $past(retValid));

  p_single_capture_r2: assert property (@(posedge clk) disable iff (rst)
    latchRef |-> !sawLatch);

  p_closed_window_r9: assert property (@(posedge clk) disable iff (rst)
    sawCheck |-> !latchRef && !evalCheck);

  p_strobe_excl_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({latchRef, evalCheck}));

endmodule

bind retire_window_chk retire_window_chk_sva u_sva (
  .clk      (clk),
  .rst      (rst),
  .retValid (retValid),
  .checkEff (checkEff),
  .latchRef (strobe.latchRef),
  .evalCheck(strobe.evalCheck),
  .errLive  (errLive),
  .errDup   (errDup)
);

// File: tb/retire_window_chk_tb.sv
module retire_window_chk_tb;

  localparam int ORDER_W = 64;
  localparam int WINDOW  = 12;
  localparam int RUN     = WINDOW + 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic retValid = 1'b0;
  logic [ORDER_W-1:0] retOrder = '0;
  logic retHalt = 1'b0;
  logic trigger = 1'b0;
  logic checkIn = 1'b0;
  logic errLive;
  logic errDup;

  int nChk  = 0;
  int nFail = 0;

  always #10 clk = ~clk;

  retire_window_chk #(
    .ORDER_W(ORDER_W),
    .WINDOW (WINDOW),
    .AUTO_CHECK(1'b1)
  ) u_dut (
    .clk(clk), .rst(rst), .retValid(retValid), .retOrder(retOrder),
    .retHalt(retHalt), .trigger(trigger), .checkIn(checkIn),
    .errLive(errLive), .errDup(errDup)
  );

  typedef struct packed {
    logic [63:0] refOrd;
    logic        refHalt;
    logic        secValid;
    logic [63:0] secOrd;
    logic        extChk;
    logic        expLive;
    logic        expDup;
  } scen_t;

  localparam int NSCEN = 9;
  localparam scen_t SCEN [NSCEN] = '{
    '{64'd100, 1'b0, 1'b1, 64'd101, 1'b1, 1'b0, 1'b0},  // R5 successor seen
    '{64'd100, 1'b0, 1'b0, 64'd0,   1'b1, 1'b1, 1'b0},  // R5 no successor
    '{64'd100, 1'b1, 1'b0, 64'd0,   1'b1, 1'b0, 1'b0},  // R6 halt exempt
    '{64'd100, 1'b0, 1'b1, 64'd100, 1'b1, 1'b1, 1'b1},  // R4 duplicate
    '{64'd100, 1'b0, 1'b1, 64'd99,  1'b1, 1'b1, 1'b0},  // R5 older index
    '{64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b1, 64'd0, 1'b1, 1'b0, 1'b0}, // R7 wrap
    '{64'd100, 1'b0, 1'b1, 64'd101, 1'b0, 1'b0, 1'b0},  // R10 auto pass
    '{64'd100, 1'b0, 1'b0, 64'd0,   1'b0, 1'b1, 1'b0},  // R10 auto fail
    '{64'd7,   1'b1, 1'b1, 64'd7,   1'b1, 1'b0, 1'b1}   // R6 R4 halt + dup
  };

  task automatic expect1(input string req, input logic act, input logic exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [63:0] o, input logic h,
                      input logic t, input logic c);
    retValid = v; retOrder = o; retHalt = h; trigger = t; checkIn = c;
    @(negedge clk);
  endtask

  task automatic doReset();
    rst = 1'b1;
    retValid = 0; retOrder = '0; retHalt = 0; trigger = 0; checkIn = 0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

  initial begin
    @(negedge clk);
    // R1 reset state
    doReset();
    expect1("R1 errLive after reset", errLive, 1'b0);
    expect1("R1 errDup after reset", errDup, 1'b0);

    // table-driven scenarios
    for (int i = 0; i < NSCEN; i++) begin
      doReset();
      step(1'b1, SCEN[i].refOrd, SCEN[i].refHalt, 1'b1, 1'b0);
      step(SCEN[i].secValid, SCEN[i].secOrd, 1'b0, 1'b0, 1'b0);
      step(1'b0, '0, 1'b0, 1'b0, 1'b0);
      step(1'b0, '0, 1'b0, 1'b0, SCEN[i].extChk);
      for (int k = 4; k < RUN; k++) step(1'b0, '0, 1'b0, 1'b0, 1'b0);
      expect1($sformatf("R5 R6 scenario %0d errLive", i), errLive, SCEN[i].expLive);
      expect1($sformatf("R4 R7 scenario %0d errDup", i), errDup, SCEN[i].expDup);
    end

    // R8 sticky after duplicate + liveness failure, then R1 reset clears
    doReset();
    step(1'b1, 64'd40, 1'b0, 1'b1, 1'b0);
    step(1'b1, 64'd40, 1'b0, 1'b0, 1'b1);
    for (int k = 0; k < 6; k++) step(1'b0, '0, 1'b0, 1'b0, 1'b0);
    expect1("R8 errLive held", errLive, 1'b1);
    expect1("R8 errDup held", errDup, 1'b1);
    doReset();
    expect1("R1 errLive cleared", errLive, 1'b0);
    expect1("R1 errDup cleared", errDup, 1'b0);

    // R3 trigger without a valid retirement captures nothing
    doReset();
    step(1'b0, 64'd5, 1'b0, 1'b1, 1'b0);
    step(1'b1, 64'd5, 1'b0, 1'b0, 1'b0);
    step(1'b1, 64'd7, 1'b0, 1'b0, 1'b1);
    step(1'b0, '0, 1'b0, 1'b0, 1'b0);
    expect1("R3 vacuous errLive", errLive, 1'b0);
    expect1("R3 vacuous errDup", errDup, 1'b0);

    // R9 retirement and trigger after the check are ignored
    doReset();
    step(1'b1, 64'd100, 1'b0, 1'b1, 1'b0);
    step(1'b1, 64'd101, 1'b0, 1'b0, 1'b0);
    step(1'b0, '0, 1'b0, 1'b0, 1'b1);
    step(1'b1, 64'd100, 1'b0, 1'b1, 1'b0);
    step(1'b1, 64'd100, 1'b0, 1'b0, 1'b1);
    step(1'b0, '0, 1'b0, 1'b0, 1'b0);
    expect1("R9 errDup after close", errDup, 1'b0);
    expect1("R9 errLive after close", errLive, 1'b0);

    // R5 successor in the check cycle itself counts
    doReset();
    step(1'b1, 64'd100, 1'b0, 1'b1, 1'b0);
    step(1'b1, 64'd101, 1'b0, 1'b0, 1'b1);
    step(1'b0, '0, 1'b0, 1'b0, 1'b0);
    expect1("R5 successor at check", errLive, 1'b0);

    // R2 a second trigger while a reference is held is ignored
    doReset();
    step(1'b1, 64'd100, 1'b0, 1'b1, 1'b0);
    step(1'b1, 64'd200, 1'b0, 1'b1, 1'b0);
    step(1'b1, 64'd101, 1'b0, 1'b0, 1'b0);
    step(1'b0, '0, 1'b0, 1'b0, 1'b1);
    step(1'b0, '0, 1'b0, 1'b0, 1'b0);
    expect1("R2 first reference kept errLive", errLive, 1'b0);
    expect1("R2 first reference kept errDup", errDup, 1'b0);

    // R4 duplicate in the check cycle
    doReset();
    step(1'b1, 64'd50, 1'b0, 1'b1, 1'b0);
    step(1'b1, 64'd51, 1'b0, 1'b0, 1'b0);
    step(1'b1, 64'd50, 1'b0, 1'b0, 1'b1);
    step(1'b0, '0, 1'b0, 1'b0, 1'b0);
    expect1("R4 duplicate at check", errDup, 1'b1);

    // R10 exact cycle of the automatic check
    doReset();
    step(1'b1, 64'd30, 1'b0, 1'b1, 1'b0);            // cycle 0
    for (int k = 1; k < WINDOW - 1; k++) step(1'b0, '0, 1'b0, 1'b0, 1'b0);
    expect1("R10 no check before cycle WINDOW-1", errLive, 1'b0);
    step(1'b0, '0, 1'b0, 1'b0, 1'b0);                // cycle WINDOW-1
    expect1("R10 auto check at cycle WINDOW-1", errLive, 1'b1);

    // R10 R9 trigger after the automatic check is ignored
    doReset();
    for (int k = 0; k < WINDOW; k++) step(1'b0, '0, 1'b0, 1'b0, 1'b0);
    step(1'b1, 64'd9, 1'b0, 1'b1, 1'b0);
    step(1'b1, 64'd9, 1'b0, 1'b0, 1'b1);
    step(1'b0, '0, 1'b0, 1'b0, 1'b0);
    expect1("R10 late trigger errDup", errDup, 1'b0);
    expect1("R10 late trigger errLive", errLive, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

endmodule